// File: doc/BRIEF.md
# Page-Buffered Byte Write Controller

This block models the write side of a byte-wide non-volatile memory that programs a whole page at a time. A write strobe loads one byte into a page register and opens a load window tied to the upper address bits of that first strobe. Further strobes for the same page add or replace bytes in the register. If no accepted strobe arrives for `LOAD_TIMEOUT` clocks, the window closes. An internal programming timer then runs for `WRITE_CYCLES` clocks and commits every loaded byte to the array in one step.

Once a byte is latched, the external bus is free. While programming runs, `busy` is high, writes are dropped, and reads return a polling status word instead of array data. The status word carries the inverse of bit 7 of the last byte loaded and a bit that flips on every read. Software polls until that bit stops toggling or `busy` falls, then starts its next access.

The controller has three states. IDLE has nothing loaded. LOAD has the window open. PROG has the timer running. It moves IDLE→LOAD on the first write strobe. It moves LOAD→PROG when the load timeout expires. It moves PROG→IDLE when the programming count ends, at the same edge as the commit.

Top module: `page_write_ctl`

## Requirements
- R1: After reset, `busy` is 0, `rdata` is 0 and every array byte reads 0.
- R2: Bytes loaded during the open window are not visible in the array. A read during LOAD returns the old array contents.
- R3: A page write can hold from 1 to 64 bytes, at byte offsets `addr[5:0]` from 0 to 63. A second strobe to an offset already loaded replaces that byte.
- R4: In LOAD, a write strobe whose page bits `addr[ADDR_W-1:6]` differ from the open page is ignored. It does not load a byte and does not restart the load timer.
- R5: `busy` rises exactly `LOAD_TIMEOUT` clock edges after the last accepted write strobe. Each accepted strobe restarts that count.
- R6: `busy` stays high for exactly `WRITE_CYCLES` clocks. The array is updated at the edge where `busy` falls.
- R7: A commit changes only the offsets loaded in that page write. Every other byte of the page keeps its value.
- R8: A read during PROG returns a status byte. Its bit 7 is the inverse of bit 7 of the last accepted byte, and bits 5:0 are 0.
- R9: Bit 6 of the status byte is 0 on the first read of a programming cycle and flips on every further read in that cycle.
- R10: A write strobe during PROG is ignored. It neither opens a new window after PROG ends nor reaches the array.
- R11: Outside PROG, a read with `rd_en` high returns the addressed array byte on `rdata` one clock later. `rdata` holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte address: page in upper bits, offset in low 6 bits |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data or polling status |
| busy | output | 1 | High while the programming timer runs |

## Verification
The bench times the load timeout to the exact edge. It places a foreign-page strobe inside the window. A design that let that strobe reset the timer would raise `busy` late, and one that latched it would corrupt another page. It reloads one offset twice, then runs a second page write of a single byte. This exposes a design that commits the whole page register or keeps stale bytes from the previous cycle. It also polls repeatedly during PROG and writes during PROG. A wrong toggle start value, a missing bit-7 inversion, or a write that leaks through after PROG ends all show up as a mismatch against the cycle model.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_LOAD = 2'd1,
        PW_PROG = 2'd2
    } pw_state_t;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
    import pw_pkg::*;
#(
    parameter int LOAD_TIMEOUT = 8,
    parameter int WRITE_CYCLES = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      page_hit,
    output pw_state_t state,
    output logic      accept,
    output logic      start_new,
    output logic      commit
);
    localparam int LT_W = $clog2(LOAD_TIMEOUT + 1);
    localparam int WC_W = $clog2(WRITE_CYCLES + 1);

    pw_state_t        state_q, state_d;
    logic [LT_W-1:0]  idle_cnt;
    logic [WC_W-1:0]  prog_cnt;
    logic             load_expired;
    logic             prog_done;

    assign load_expired = (idle_cnt == LT_W'(LOAD_TIMEOUT - 1));
    assign prog_done    = (prog_cnt == WC_W'(WRITE_CYCLES - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE: if (wr_en)                   state_d = PW_LOAD;
            PW_LOAD: if (!accept && load_expired) state_d = PW_PROG;
            PW_PROG: if (prog_done)               state_d = PW_IDLE;
            default:                              state_d = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PW_IDLE;
            idle_cnt <= '0;
            prog_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (accept)                idle_cnt <= '0;
            else if (state_q == PW_LOAD) idle_cnt <= idle_cnt + 1'b1;
            if (state_q == PW_PROG)    prog_cnt <= prog_cnt + 1'b1;
            else                       prog_cnt <= '0;
        end
    end

    always_comb begin
        state     = state_q;
        start_new = 1'b0;
        accept    = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            PW_IDLE: begin
                start_new = wr_en;
                accept    = wr_en;
            end
            PW_LOAD: accept = wr_en && page_hit;
            PW_PROG: commit = prog_done;
            default: ;
        endcase
    end

    // R6
    prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_PROG && state_d == PW_IDLE) |-> commit);

    // R10
    prog_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PW_PROG) |-> !accept);
endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 6,
    parameter int DATA_W    = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   accept,
    input  logic                                   start_new,
    input  logic [ADDR_W-1:0]                      addr,
    input  logic [DATA_W-1:0]                      wdata,
    output logic [(1<<PAGE_BITS)-1:0]              mask,
    output logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0]  bytes_q,
    output logic [ADDR_W-PAGE_BITS-1:0]            open_page,
    output logic [DATA_W-1:0]                      last_byte
);
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    logic [PAGE_BITS-1:0] offset;
    assign offset = addr[PAGE_BITS-1:0];

    for (genvar i = 0; i < PAGE_SIZE; i++) begin : g_slot
        logic hit;
        assign hit = accept && (offset == PAGE_BITS'(i));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask[i]    <= 1'b0;
                bytes_q[i] <= '0;
            end else begin
                if (hit) begin
                    mask[i]    <= 1'b1;
                    bytes_q[i] <= wdata;
                end else if (start_new) begin
                    mask[i]    <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_page <= '0;
            last_byte <= '0;
        end else if (accept) begin
            last_byte <= wdata;
            if (start_new) open_page <= addr[ADDR_W-1:PAGE_BITS];
        end
    end
endmodule

// File: rtl/pw_array.sv
module pw_array #(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 6,
    parameter int DATA_W    = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   commit,
    input  logic [(1<<PAGE_BITS)-1:0]              mask,
    input  logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0]  bytes_q,
    input  logic [ADDR_W-PAGE_BITS-1:0]            commit_page,
    input  logic                                   busy,
    input  logic                                   rd_en,
    input  logic [ADDR_W-1:0]                      rd_addr,
    input  logic [DATA_W-1:0]                      last_byte,
    output logic [DATA_W-1:0]                      rdata
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              toggle;
    logic [DATA_W-1:0] status;

    assign status = {~last_byte[DATA_W-1], toggle, (DATA_W-2)'(0)};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PAGE_SIZE; i++)
                if (mask[i]) mem[{commit_page, PAGE_BITS'(i)}] <= bytes_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            toggle <= 1'b0;
        end else begin
            if (!busy)      toggle <= 1'b0;
            else if (rd_en) toggle <= ~toggle;
            if (rd_en) rdata <= busy ? status : mem[rd_addr];
        end
    end

    // R8
    poll_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rdata[DATA_W-1] != $past(last_byte[DATA_W-1])));

    // R9
    poll_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && $past(rd_en && busy)) |=> (rdata[DATA_W-2] != $past(rdata[DATA_W-2])));
endmodule

// File: rtl/page_write_ctl.sv
module page_write_ctl
    import pw_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PAGE_BITS    = 6,
    parameter int LOAD_TIMEOUT = 8,
    parameter int WRITE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy
);
    localparam int DATA_W    = 8;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;
    localparam int PG_W      = ADDR_W - PAGE_BITS;

    pw_state_t                          state;
    logic                               accept, start_new, commit, page_hit;
    logic [PAGE_SIZE-1:0]               mask;
    logic [PAGE_SIZE-1:0][DATA_W-1:0]   bytes_q;
    logic [PG_W-1:0]                    open_page;
    logic [DATA_W-1:0]                  last_byte;

    assign page_hit = (addr[ADDR_W-1:PAGE_BITS] == open_page);
    assign busy     = (state == PW_PROG);

    pw_ctrl #(.LOAD_TIMEOUT(LOAD_TIMEOUT), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .page_hit(page_hit),
        .state(state), .accept(accept), .start_new(start_new), .commit(commit)
    );

    pw_page_buf #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .accept(accept), .start_new(start_new),
        .addr(addr), .wdata(wdata), .mask(mask), .bytes_q(bytes_q),
        .open_page(open_page), .last_byte(last_byte)
    );

    pw_array #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit), .mask(mask), .bytes_q(bytes_q),
        .commit_page(open_page), .busy(busy), .rd_en(rd_en), .rd_addr(addr),
        .last_byte(last_byte), .rdata(rdata)
    );

    // R4
    foreign_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_LOAD && wr_en && !page_hit) |=> ($stable(mask) && $stable(last_byte)));

    // R3
    window_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PW_LOAD) |-> (mask != '0));

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(commit));
endmodule

// File: tb/page_write_ctl_tb.sv
`timescale 1ns/1ps
module page_write_ctl_tb;
    localparam int AW = 10;
    localparam int LT = 6;
    localparam int WC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          busy;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    page_write_ctl #(.ADDR_W(AW), .PAGE_BITS(6), .LOAD_TIMEOUT(LT), .WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    // behavioural reference model
    int        m_mode = 0, m_idle = 0, m_wc = 0, m_page = 0;
    byte       m_mem [int];
    byte       m_buf [int];
    logic [7:0] m_last = 0, m_rd = 0;
    bit        m_tog = 0;

    function automatic logic [7:0] mem_rd(int a);
        return m_mem.exists(a) ? m_mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_idle = 0; m_wc = 0; m_rd = 0; m_tog = 0; m_last = 0;
            m_mem.delete(); m_buf.delete();
        end else begin
            if (rd_en) begin
                if (m_mode == 2) begin
                    m_rd = {~m_last[7], m_tog, 6'b0};
                    m_tog = ~m_tog;
                end else m_rd = mem_rd(int'(addr));
            end
            case (m_mode)
                0: if (wr_en) begin
                    m_buf.delete();
                    m_buf[int'(addr[5:0])] = wdata;
                    m_page = int'(addr[AW-1:6]); m_last = wdata;
                    m_mode = 1; m_idle = 0;
                end
                1: if (wr_en && int'(addr[AW-1:6]) == m_page) begin
                    m_buf[int'(addr[5:0])] = wdata; m_last = wdata; m_idle = 0;
                end else if (m_idle == LT - 1) begin
                    m_mode = 2; m_wc = 0; m_tog = 0;
                end else m_idle++;
                default: if (m_wc == WC - 1) begin
                    foreach (m_buf[k]) m_mem[m_page * 64 + k] = m_buf[k];
                    m_mode = 0;
                end else m_wc++;
            endcase
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) if (rst_n && !finished) begin
        check("R5/R6 busy vs model", {7'b0, busy}, {7'b0, (m_mode == 2)});
        check("R8/R9/R11 rdata vs model", rdata, m_rd);
    end

    task automatic wr(int a, logic [7:0] d);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [7:0] v);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin
        #(200000 * 8);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", {7'b0, busy}, 8'h00);
        check("R1 rdata after reset", rdata, 8'h00);
        rd(200, v); check("R1 array cleared", v, 8'h00);

        // page 2 = addresses 128..191
        wr(128 + 0, 8'hA1);
        wr(128 + 1, 8'hB2);
        rd(128 + 0, v); check("R2 buffered byte not in array", v, 8'h00);
        wr(192 + 0, 8'h55);              // foreign page 3, ignored
        wr(128 + 63, 8'hC3);
        wr(128 + 1, 8'hD4);              // overwrite, last accepted byte
        repeat (LT - 1) @(negedge clk);
        check("R5 busy low before timeout", {7'b0, busy}, 8'h00);
        @(negedge clk);
        check("R5 busy high at timeout", {7'b0, busy}, 8'h01);
        cnt = 1;
        rd(128, v); cnt++;
        check("R8 poll status first", v, {~8'hD4 >> 7 & 8'h01, 7'b0});
        rd(128, v); cnt++;
        check("R9 poll toggle second", v, 8'h40);
        wr(320, 8'h77); cnt++;           // during PROG, ignored
        while (busy) begin @(negedge clk); cnt++; end
        check("R6 busy length", 8'(cnt - 1), 8'(WC));
        repeat (LT + 2) @(negedge clk);
        check("R10 no window after PROG", {7'b0, busy}, 8'h00);
        rd(128 + 0, v);  check("R3 offset 0 committed", v, 8'hA1);
        rd(128 + 1, v);  check("R3 overwritten offset", v, 8'hD4);
        rd(128 + 63, v); check("R3 offset 63 committed", v, 8'hC3);
        rd(128 + 2, v);  check("R7 unloaded offset untouched", v, 8'h00);
        rd(192, v);      check("R4 foreign page untouched", v, 8'h00);
        rd(320, v);      check("R10 write in PROG dropped", v, 8'h00);

        // single-byte page write into the same page
        wr(128 + 2, 8'h11);
        while (!busy) @(negedge clk);
        rd(0, v); check("R8 poll msb with bit7 clear", v, 8'h80);
        while (busy) @(negedge clk);
        rd(128 + 2, v);  check("R3 single byte write", v, 8'h11);
        rd(128 + 0, v);  check("R7 earlier byte kept", v, 8'hA1);
        rd(128 + 63, v); check("R7 earlier byte kept hi", v, 8'hC3);
        @(negedge clk);
        check("R11 rdata holds without rd_en", rdata, 8'hC3);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule